// File: doc/BRIEF.md
# Configurable Endianness Host Bus Adapter

This block sits between a narrow external CPU bus and a file of 32-bit quadlet registers. The CPU bus is 8 or 16 bits wide. Each host access carries a byte address. The adapter splits that address into a quadlet index and a position inside the quadlet. It steers the host data lanes onto the right byte or halfword of the quadlet, and it drives per-byte enables so that a narrow write changes only the lanes it addresses. Reads come back through the same steering, in the other direction.

Two strap inputs select the byte ordering: little-endian and data-invariant. Both are captured while reset is asserted, and the values present at the clock edge just before reset releases are kept until the next reset. The bus-width select is a static input. The two straps act together with the bus width:
- Little-endian with data-invariant reverses the position of the access inside the quadlet.
- Little-endian without data-invariant, on a 16-bit bus, swaps the two bytes of every halfword.
- Every other combination uses plain big-endian numbering.

A fixed, read-only shadow quadlet at byte offset 0x0F4 lets software find out which ordering is in effect.

Host requests use a valid/ready handshake. A request is taken on a clock edge where `hreq_valid` and `hreq_ready` are both high. While a read response is waiting, `hreq_ready` is low, so the host must hold its request. A read response stays valid, with stable data, until the host accepts it with `hrsp_ready`. Writes return no response.

Top module: `endian_host_adapter`

## Requirements
- R1: The little-endian and data-invariant straps are sampled on every clock edge while `rst_n` is low. The values taken at the last such edge apply until the next reset, and later strap changes have no effect.
- R2: A read at byte offset 0x0F4 (quadlet 0x3D) returns the quadlet 0x0F0A0500 instead of register data. In the plain 8-bit mode, byte offsets 0..3 of that quadlet return 0x0F, 0x0A, 0x05 and 0x00. A write to that quadlet raises neither `reg_wr` nor `reg_rd`, and the shadow value is unchanged.
- R3: In the plain 8-bit mode, byte offset k (address bits 1:0) reaches quadlet bits [31-8k : 24-8k]. Read data appears on `hrsp_rdata[7:0]` with bits 15:8 at zero, and `hreq_wdata[15:8]` is ignored.
- R4: In the plain 16-bit mode, address bit 1 at 0 reaches bits 31:16 and at 1 reaches bits 15:0. Address bit 0 is ignored, and `hreq_wdata[15:8]` maps to the upper byte of the selected halfword.
- R5: With both straps at 1 on the 8-bit bus, address bits 1:0 are inverted before the R3 mapping is applied, so offset 0 reaches bits 7:0.
- R6: With both straps at 1 on the 16-bit bus, address bit 1 is inverted before the R4 mapping is applied, so offset 0 reaches bits 15:0.
- R7: With little-endian at 1 and data-invariant at 0 on the 16-bit bus, the R4 address mapping applies, but the two data bytes are exchanged on both writes and reads.
- R8: With little-endian at 1 and data-invariant at 0 on the 8-bit bus, the mapping is exactly the R3 mapping.
- R9: In every mode, `reg_qaddr` equals address bits ADDR_W-1:2. Consecutive quadlets therefore keep their order, and the most significant quadlet of a multi-quadlet operand stays at the lowest address.
- R10: A write asserts `reg_be` on exactly the addressed lanes: one lane on the 8-bit bus, lanes 3:2 or 1:0 on the 16-bit bus. The other bytes of the quadlet keep their values.
- R11: After reset, `hrsp_valid` is 0 and `hreq_ready` is 1. An accepted read raises `hrsp_valid` on the next cycle. That response holds with stable data while `hrsp_ready` is low, and `hreq_ready` is low for as long as it is pending. An accepted write produces no response and pulses `reg_wr` in its acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; straps are captured while it is low |
| strap_le | input | 1 | Little-endian strap |
| strap_di | input | 1 | Data-invariant strap |
| bus16 | input | 1 | Static bus width select: 1 = 16-bit, 0 = 8-bit |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Adapter can take a request |
| hreq_write | input | 1 | 1 = write, 0 = read |
| hreq_addr | input | ADDR_W | Host byte address |
| hreq_wdata | input | 16 | Host write data (bits 7:0 only on the 8-bit bus) |
| hrsp_valid | output | 1 | Read response valid |
| hrsp_ready | input | 1 | Host takes the read response |
| hrsp_rdata | output | 16 | Read response data |
| reg_rd | output | 1 | Register file read strobe |
| reg_wr | output | 1 | Register file write strobe |
| reg_qaddr | output | ADDR_W-2 | Quadlet index |
| reg_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| reg_wdata | output | 32 | Quadlet write data with lanes replicated |
| reg_rdata | input | 32 | Register file read data, combinational from reg_qaddr |

## Verification
A write reaches the register file at the same edge that accepts it, so the bench checks the file contents at the following falling edge. A read result is registered once and is due one cycle after acceptance. The bench samples `hrsp_valid` and `hrsp_rdata` at the falling edge right after the accepting edge, and it checks that the response stays stable through every cycle that `hrsp_ready` holds it back. Strap changes after reset are followed by a read, and that read is checked against the mapping latched at reset.

// File: rtl/hba_pkg.sv
package hba_pkg;
  typedef enum logic [1:0] {
    MAP_PLAIN  = 2'd0,
    MAP_INVERT = 2'd1,
    MAP_SWAP   = 2'd2
  } map_e;

  function automatic map_e pick_map(input logic le, input logic di, input logic wide);
    if (le && di)        return MAP_INVERT;
    else if (le && wide) return MAP_SWAP;
    else                 return MAP_PLAIN;
  endfunction
endpackage

// File: rtl/hba_strap_latch.sv
module hba_strap_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strap_in,
  output logic [N-1:0] strap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  // R1: the latched straps do not move while out of reset
  a_r1_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap_q));
endmodule

// File: rtl/hba_lane_map.sv
module hba_lane_map
  import hba_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  map_e              mode,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [31:0]       rdata_q,
  output logic [ADDR_W-3:0] qaddr,
  output logic [3:0]        be,
  output logic [31:0]       wdata_q,
  output logic [15:0]       rdata_h
);
  logic       inv, swp, hsel;
  logic [1:0] ib, blane;
  logic [15:0] hw_in, half;
  logic [7:0]  bsel;

  assign inv   = (mode == MAP_INVERT);
  assign swp   = (mode == MAP_SWAP);
  assign qaddr = addr[ADDR_W-1:2];
  assign ib    = addr[1:0] ^ {2{inv}};   // internal byte number, 0 = most significant
  assign hsel  = addr[1] ^ inv;          // 0 = upper halfword
  assign blane = 2'd3 - ib;              // lane number, 3 = bits 31:24

  for (genvar g = 0; g < 4; g++) begin : g_be
    localparam logic LOWER = (g < 2);
    assign be[g] = wide ? (hsel == LOWER) : (blane == 2'(g));
  end

  assign hw_in   = swp ? {wdata[7:0], wdata[15:8]} : wdata;
  assign wdata_q = wide ? {hw_in, hw_in} : {4{wdata[7:0]}};

  assign half = hsel ? rdata_q[15:0] : rdata_q[31:16];

  always_comb begin
    case (blane)
      2'd3:    bsel = rdata_q[31:24];
      2'd2:    bsel = rdata_q[23:16];
      2'd1:    bsel = rdata_q[15:8];
      default: bsel = rdata_q[7:0];
    endcase
  end

  always_comb begin
    if (wide) rdata_h = swp ? {half[7:0], half[15:8]} : half;
    else      rdata_h = {8'h00, bsel};
  end
endmodule

// File: rtl/hba_rsp_stage.sv
module hba_rsp_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11: a response that is held back stays valid with the same data
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/endian_host_adapter.sv
module endian_host_adapter
  import hba_pkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter logic [31:0] SHADOW_OFS = 32'h0000_00F4,
  parameter logic [31:0] SHADOW_VAL = 32'h0F0A_0500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_le,
  input  logic              strap_di,
  input  logic              bus16,
  input  logic              hreq_valid,
  output logic              hreq_ready,
  input  logic              hreq_write,
  input  logic [ADDR_W-1:0] hreq_addr,
  input  logic [15:0]       hreq_wdata,
  output logic              hrsp_valid,
  input  logic              hrsp_ready,
  output logic [15:0]       hrsp_rdata,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [ADDR_W-3:0] reg_qaddr,
  output logic [3:0]        reg_be,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata
);
  localparam logic [ADDR_W-3:0] SHADOW_Q = SHADOW_OFS[ADDR_W-1:2];

  logic [1:0]  straps;
  map_e        mode;
  logic        accept, hit_shadow;
  logic [31:0] src_q;
  logic [15:0] rd_h;

  hba_strap_latch #(.N(2)) u_straps (
    .clk(clk), .rst_n(rst_n),
    .strap_in({strap_le, strap_di}), .strap_q(straps)
  );

  assign mode = pick_map(straps[1], straps[0], bus16);

  hba_lane_map #(.ADDR_W(ADDR_W)) u_map (
    .mode(mode), .wide(bus16), .addr(hreq_addr), .wdata(hreq_wdata),
    .rdata_q(src_q), .qaddr(reg_qaddr), .be(reg_be),
    .wdata_q(reg_wdata), .rdata_h(rd_h)
  );

  assign hreq_ready = !hrsp_valid;
  assign accept     = hreq_valid && hreq_ready;
  assign hit_shadow = (reg_qaddr == SHADOW_Q);
  assign reg_wr     = accept && hreq_write && !hit_shadow;
  assign reg_rd     = accept && !hreq_write && !hit_shadow;
  assign src_q      = hit_shadow ? SHADOW_VAL : reg_rdata;

  hba_rsp_stage #(.W(16)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load(accept && !hreq_write), .din(rd_h),
    .out_ready(hrsp_ready), .out_valid(hrsp_valid), .out_data(hrsp_rdata)
  );

  // R10: a narrow write enables a single lane
  a_r10_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !bus16) |-> ($countones(reg_be) == 1));
  // R10: a 16-bit write enables one aligned halfword
  a_r10_half_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && bus16) |-> (reg_be == 4'b1100 || reg_be == 4'b0011));
  // R2: the shadow quadlet never reaches the register file
  a_r2_shadow_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (reg_qaddr != SHADOW_Q));
  // R11: a write never produces a response
  a_r11_wr_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hreq_write) |=> !hrsp_valid);
  // R11: an accepted read is answered on the next cycle
  a_r11_rd_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hreq_write) |=> hrsp_valid);
endmodule

// File: tb/endian_host_adapter_test.sv
module endian_host_adapter_test;
  localparam int ADDR_W = 10;
  localparam int NQ = 1 << (ADDR_W - 2);
  localparam int SHQ = 'h3D;

  logic clk = 0, rst_n = 0;
  logic strap_le = 0, strap_di = 0, bus16 = 0;
  logic hreq_valid = 0, hreq_write = 0, hreq_ready;
  logic [ADDR_W-1:0] hreq_addr = '0;
  logic [15:0] hreq_wdata = '0, hrsp_rdata;
  logic hrsp_valid, hrsp_ready = 1;
  logic reg_rd, reg_wr;
  logic [ADDR_W-3:0] reg_qaddr;
  logic [3:0] reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic preload = 0;
  logic [31:0] mem [NQ];
  logic [31:0] expm [NQ];
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit cur_le, cur_di, cur_w, finished = 0;

  always #5 clk = ~clk;

  endian_host_adapter #(.ADDR_W(ADDR_W)) uut (.*);

  function automatic logic [31:0] pre(int i);
    logic [7:0] b = 8'(i);
    return {b, ~b, b ^ 8'h5A, 8'hC3};
  endfunction

  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < NQ; i++) mem[i] <= pre(i);
    end else if (reg_wr) begin
      for (int b = 0; b < 4; b++)
        if (reg_be[b]) mem[reg_qaddr][8*b +: 8] <= reg_wdata[8*b +: 8];
    end
  end
  assign reg_rdata = mem[reg_qaddr];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag();
    if (cur_le && cur_di) return cur_w ? "R6" : "R5";
    if (cur_le && cur_w)  return "R7";
    if (cur_le)           return "R8";
    return cur_w ? "R4" : "R3";
  endfunction

  function automatic logic [31:0] qval(int q);
    return (q == SHQ) ? 32'h0F0A0500 : expm[q];
  endfunction

  function automatic logic [15:0] exp_read(logic [ADDR_W-1:0] a);
    logic [31:0] v = qval(int'(a[ADDR_W-1:2]));
    bit inv = cur_le && cur_di;
    bit sw = cur_le && !cur_di && cur_w;
    logic [1:0] pos;
    logic h;
    logic [15:0] r;
    if (!cur_w) begin
      pos = a[1:0] ^ {inv, inv};
      return {8'h00, v[31 - 8*pos -: 8]};
    end
    h = a[1] ^ inv;
    r = h ? v[15:0] : v[31:16];
    return sw ? {r[7:0], r[15:8]} : r;
  endfunction

  task automatic exp_write(logic [ADDR_W-1:0] a, logic [15:0] d);
    int q = int'(a[ADDR_W-1:2]);
    bit inv = cur_le && cur_di;
    bit sw = cur_le && !cur_di && cur_w;
    logic [1:0] pos;
    logic h;
    if (q == SHQ) return;
    if (!cur_w) begin
      pos = a[1:0] ^ {inv, inv};
      expm[q][31 - 8*pos -: 8] = d[7:0];
    end else begin
      h = a[1] ^ inv;
      expm[q][31 - 16*h -: 8] = sw ? d[7:0] : d[15:8];
      expm[q][23 - 16*h -: 8] = sw ? d[15:8] : d[7:0];
    end
  endtask

  task automatic do_reset(bit le, bit di, bit w);
    @(negedge clk);
    rst_n = 0; strap_le = le; strap_di = di; bus16 = w; preload = 1;
    @(negedge clk);
    preload = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    cur_le = le; cur_di = di; cur_w = w;
    for (int i = 0; i < NQ; i++) expm[i] = pre(i);
    @(negedge clk);
    chk("R11 reset valid", {31'b0, hrsp_valid}, 32'd0);
    chk("R11 reset ready", {31'b0, hreq_ready}, 32'd1);
  endtask

  task automatic host_write(logic [ADDR_W-1:0] a, logic [15:0] d);
    @(negedge clk);
    hreq_valid = 1; hreq_write = 1; hreq_addr = a; hreq_wdata = d;
    while (!hreq_ready) @(negedge clk);
    @(negedge clk);
    hreq_valid = 0;
    exp_write(a, d);
  endtask

  task automatic host_read(logic [ADDR_W-1:0] a, output logic [15:0] d);
    @(negedge clk);
    hreq_valid = 1; hreq_write = 0; hreq_addr = a;
    while (!hreq_ready) @(negedge clk);
    @(negedge clk);
    hreq_valid = 0;
    chk("R11 read due", {31'b0, hrsp_valid}, 32'd1);
    d = hrsp_rdata;
  endtask

  task automatic read_chk(string tag, logic [ADDR_W-1:0] a);
    logic [15:0] d;
    host_read(a, d);
    chk(tag, {16'h0, d}, {16'h0, exp_read(a)});
  endtask

  initial begin
    logic [15:0] d, held;
    void'($urandom(32'd20240611));

    // R2: shadow in plain 8-bit mode, byte by byte
    do_reset(0, 0, 0);
    host_read(10'h0F4, d); chk("R2 shadow b0", {16'h0, d}, 32'h0F);
    host_read(10'h0F5, d); chk("R2 shadow b1", {16'h0, d}, 32'h0A);
    host_read(10'h0F6, d); chk("R2 shadow b2", {16'h0, d}, 32'h05);
    host_read(10'h0F7, d); chk("R2 shadow b3", {16'h0, d}, 32'h00);
    host_write(10'h0F4, 16'h00EE);
    chk("R2 shadow store untouched", mem[SHQ], pre(SHQ));
    host_read(10'h0F4, d); chk("R2 shadow read-only", {16'h0, d}, 32'h0F);
    // R3: upper host data ignored on the 8-bit bus
    host_write(10'h011, 16'hAB77);
    chk("R3 lane 23:16", mem[4], {pre(4)[31:24], 8'h77, pre(4)[15:0]});

    // Random traffic in every strap and width combination
    for (int m = 0; m < 8; m++) begin
      do_reset(m[2], m[1], m[0]);
      read_chk({mode_tag(), " shadow"}, 10'h0F4);
      read_chk({mode_tag(), " shadow"}, 10'h0F6);
      for (int k = 0; k < 60; k++) begin
        int q = int'($urandom % NQ);
        logic [ADDR_W-1:0] a;
        if (q == SHQ) q = SHQ + 1;
        a = {8'(q), 2'($urandom % 4)};
        if ($urandom % 2) begin
          host_write(a, 16'($urandom));
          chk("R10 quadlet after write", mem[q], expm[q]);
        end else begin
          read_chk(mode_tag(), a);
        end
      end
    end

    // R9: adjacent quadlets keep their order in invert mode
    do_reset(1, 1, 1);
    host_write(10'h040, 16'h1122);
    host_write(10'h044, 16'h3344);
    chk("R9 lower quadlet", mem[16], {pre(16)[31:16], 16'h1122});
    chk("R9 upper quadlet", mem[17], {pre(17)[31:16], 16'h3344});
    // R6: offset 0 reaches bits 15:0
    read_chk("R6 offset0", 10'h040);

    // R1: straps changed after reset have no effect
    do_reset(1, 1, 0);
    strap_le = 0; strap_di = 0;
    repeat (3) @(negedge clk);
    host_read(10'h014, d);
    chk("R1 latched strap", {16'h0, d}, {24'h0, pre(5)[7:0]});
    host_write(10'h014, 16'h005D);
    chk("R1 latched write lane", mem[5], {pre(5)[31:8], 8'h5D});

    // R7: byte swap on the 16-bit bus
    do_reset(1, 0, 1);
    host_write(10'h022, 16'hBEEF);
    chk("R7 swapped write", mem[8], {pre(8)[31:16], 16'hEFBE});
    host_read(10'h022, d); chk("R7 swapped read", {16'h0, d}, 32'hBEEF);

    // R11: back-pressure holds the response and blocks requests
    do_reset(0, 0, 1);
    hrsp_ready = 0;
    host_read(10'h030, d);
    held = d;
    chk("R4 upper half", {16'h0, d}, {16'h0, pre(12)[31:16]});
    @(negedge clk);
    hreq_valid = 1; hreq_write = 1; hreq_addr = 10'h032; hreq_wdata = 16'h6A6A;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 held valid", {31'b0, hrsp_valid}, 32'd1);
      chk("R11 held data", {16'h0, hrsp_rdata}, {16'h0, held});
      chk("R11 busy not ready", {31'b0, hreq_ready}, 32'd0);
    end
    chk("R11 no write while busy", mem[12], pre(12));
    hrsp_ready = 1;
    @(negedge clk);
    @(negedge clk);
    hreq_valid = 0;
    exp_write(10'h032, 16'h6A6A);
    chk("R11 write after release", mem[12], expm[12]);
    chk("R11 write no response", {31'b0, hrsp_valid}, 32'd0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule